// File: doc/BRIEF.md
# Page-Granular Cache Move-In Controller

This block decides when lines may be moved into a processor cache and emits the resulting line-fill requests. A reference brings in a whole page at a time. A data reference brings in every line of its page. An instruction reference brings in every line of its page and then every line of the page that follows. Fill requests leave one line address per cycle under a valid/ready handshake. The addresses rise from the page base.

Flush, cache-purge and translation-purge operations mark a page as inhibited. While a page is marked, the block issues no fill for it. A fresh reference to that page removes the mark. The marks live in a small table with round-robin replacement.

A speculative reference may start a fill only under three conditions: its translation hits in the TLB, address translation is enabled in the processor status, and the TLB entry is cacheable. If any of these fails, the reference is dropped without any effect. A new accepted reference aborts any burst in progress.

Top module: `movein_ctrl`

## Requirements
- R1: A data reference (`ref_instr_i`=0) leads to 64 fetches, one per 64-byte line of its 4 KB page. They run in ascending order from the page base, whatever the line offset of the reference. The first fetch is valid in the cycle after the reference.
- R2: An instruction reference (`ref_instr_i`=1) leads to 128 fetches. These are the 64 lines of its page followed by the 64 lines of the next page, in ascending order.
- R3: A speculative reference (`ref_spec_i`=1) starts a burst when `tlb_hit_i`=1, `tlb_uncache_i`=0 and `xlate_en_i`=1.
- R4: A speculative reference with a TLB miss, with the uncacheable bit set, or with translation disabled issues no fetch. It leaves a burst already in progress unchanged.
- R5: After an inhibit command for a page (`inh_page_i` = address bits 31:12), no fetch for that page is valid from the next cycle on. The rest of that page's part of the burst is dropped.
- R6: An inhibit persists across references to other pages. A new reference to the inhibited page clears it.
- R7: In an instruction burst, an inhibited first page is skipped and the burst moves on to the next page. An inhibited second page ends the burst after the first page.
- R8: An accepted reference during a burst aborts that burst, and the next cycle starts the new page's burst at its base.
- R9: While `fetch_valid_o`=1 and `fetch_ready_i`=0, the fetch address and valid stay stable unless a reference or inhibit command arrives.
- R10: During and right after reset, `fetch_valid_o` is low.
- R11: The inhibit table holds 4 pages. A fifth inhibit replaces the oldest entry, and the other entries stay in force.
- R12: When an inhibit command and a reference to the same page arrive in the same cycle, the inhibit wins and no fetch is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | Reference present this cycle |
| ref_addr_i | input | 32 | Byte address of the reference |
| ref_instr_i | input | 1 | 1 = instruction reference, 0 = data reference |
| ref_spec_i | input | 1 | Reference is speculative |
| tlb_hit_i | input | 1 | Translation found in the TLB |
| tlb_uncache_i | input | 1 | TLB entry is marked uncacheable |
| xlate_en_i | input | 1 | Processor-status translation enable |
| inh_valid_i | input | 1 | Inhibit command from a flush or purge |
| inh_page_i | input | 20 | Page number to inhibit |
| fetch_valid_o | output | 1 | Line fetch request valid |
| fetch_ready_i | input | 1 | Memory side accepts the request |
| fetch_addr_o | output | 32 | Line-aligned fetch address |

## Verification
The checker watches several behaviours on every cycle:
- handshake stability while stalled;
- forward-only movement of the fetch address;
- the start of each accepted burst at its page base;
- the absence of any fetch to a page the cycle after it is inhibited;
- the silence of a rejected speculative reference when idle.

Other behaviours can only be shown by the bench's scenarios, because they need whole sequences:
- the exact count and order of fetches;
- the skip to the second page;
- the clearing of an inhibit by a later reference;
- round-robin eviction in the table.

// File: rtl/movein_pkg.sv
package movein_pkg;
  typedef enum logic {
    REF_DATA  = 1'b0,
    REF_INSTR = 1'b1
  } ref_kind_e;
endpackage

// File: rtl/movein_inhibit_tbl.sv
module movein_inhibit_tbl #(
  parameter int PAGE_W = 20,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [PAGE_W-1:0] set_page_i,
  input  logic              clr_i,
  input  logic [PAGE_W-1:0] clr_page_i,
  input  logic [PAGE_W-1:0] probe_page_i,
  output logic              hit_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PAGE_W-1:0] page_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  match;
  logic [PTR_W-1:0]  ptr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (page_q[g] == probe_page_i);
  end
  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) page_q[i] <= '0;
    end else begin
      if (clr_i) begin
        for (int i = 0; i < DEPTH; i++)
          if (page_q[i] == clr_page_i) vld_q[i] <= 1'b0;
      end
      // set after clear: an inhibit in the same cycle wins
      if (set_i) begin
        page_q[ptr_q] <= set_page_i;
        vld_q[ptr_q]  <= 1'b1;
        ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/movein_burst.sv
module movein_burst #(
  parameter int LIDX_W   = 26,
  parameter int LPP_BITS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LIDX_W-1:0] start_line_i,
  input  logic              two_pages_i,
  input  logic              skip_i,
  input  logic              adv_i,
  output logic              busy_o,
  output logic [LIDX_W-1:0] line_o
);
  localparam logic [LIDX_W-1:0] SPAN1_M1 = LIDX_W'((1 << LPP_BITS) - 1);
  localparam logic [LIDX_W-1:0] SPAN2_M1 = LIDX_W'((2 << LPP_BITS) - 1);

  logic [LIDX_W-1:0] cur_q, last_q, base;
  logic              busy_q;

  assign base   = {start_line_i[LIDX_W-1:LPP_BITS], {LPP_BITS{1'b0}}};
  assign busy_o = busy_q;
  assign line_o = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cur_q  <= base;
      last_q <= base + (two_pages_i ? SPAN2_M1 : SPAN1_M1);
    end else if (busy_q) begin
      if (skip_i) begin
        if (cur_q[LIDX_W-1:LPP_BITS] != last_q[LIDX_W-1:LPP_BITS])
          cur_q <= {last_q[LIDX_W-1:LPP_BITS], {LPP_BITS{1'b0}}};
        else
          busy_q <= 1'b0;
      end else if (adv_i) begin
        if (cur_q == last_q) busy_q <= 1'b0;
        else                 cur_q  <= cur_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/movein_ctrl.sv
module movein_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6,
  parameter int INH_DEPTH = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ref_valid_i,
  input  logic [ADDR_W-1:0]           ref_addr_i,
  input  logic                        ref_instr_i,
  input  logic                        ref_spec_i,
  input  logic                        tlb_hit_i,
  input  logic                        tlb_uncache_i,
  input  logic                        xlate_en_i,
  input  logic                        inh_valid_i,
  input  logic [ADDR_W-PAGE_BITS-1:0] inh_page_i,
  output logic                        fetch_valid_o,
  input  logic                        fetch_ready_i,
  output logic [ADDR_W-1:0]           fetch_addr_o
);
  import movein_pkg::*;

  localparam int PAGE_W   = ADDR_W - PAGE_BITS;
  localparam int LIDX_W   = ADDR_W - LINE_BITS;
  localparam int LPP_BITS = PAGE_BITS - LINE_BITS;

  ref_kind_e         kind;
  logic              ref_ok, burst_busy, inh_hit, fire;
  logic [LIDX_W-1:0] cur_line;
  logic [PAGE_W-1:0] cur_page, ref_page;

  assign kind     = ref_kind_e'(ref_instr_i);
  assign ref_page = ref_addr_i[ADDR_W-1:PAGE_BITS];
  // speculative move-in needs a cacheable translation with translation enabled
  assign ref_ok   = ref_valid_i &&
                    (!ref_spec_i || (tlb_hit_i && !tlb_uncache_i && xlate_en_i));
  assign cur_page = cur_line[LIDX_W-1:LPP_BITS];

  movein_inhibit_tbl #(
    .PAGE_W(PAGE_W),
    .DEPTH (INH_DEPTH)
  ) i_tbl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (inh_valid_i),
    .set_page_i  (inh_page_i),
    .clr_i       (ref_ok),
    .clr_page_i  (ref_page),
    .probe_page_i(cur_page),
    .hit_o       (inh_hit)
  );

  movein_burst #(
    .LIDX_W  (LIDX_W),
    .LPP_BITS(LPP_BITS)
  ) i_burst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (ref_ok),
    .start_line_i(ref_addr_i[ADDR_W-1:LINE_BITS]),
    .two_pages_i (kind == REF_INSTR),
    .skip_i      (inh_hit),
    .adv_i       (fire),
    .busy_o      (burst_busy),
    .line_o      (cur_line)
  );

  assign fetch_valid_o = burst_busy && !inh_hit;
  assign fire          = fetch_valid_o && fetch_ready_i;
  assign fetch_addr_o  = {cur_line, {LINE_BITS{1'b0}}};
endmodule

// File: rtl/movein_ctrl_chk.sv
module movein_ctrl_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int LINE_BITS = 6
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        ref_valid_i,
  input logic [ADDR_W-1:0]           ref_addr_i,
  input logic                        ref_spec_i,
  input logic                        tlb_hit_i,
  input logic                        tlb_uncache_i,
  input logic                        xlate_en_i,
  input logic                        inh_valid_i,
  input logic [ADDR_W-PAGE_BITS-1:0] inh_page_i,
  input logic                        fetch_valid_o,
  input logic                        fetch_ready_i,
  input logic [ADDR_W-1:0]           fetch_addr_o,
  input logic                        busy_i
);
  localparam logic [ADDR_W-1:0] LINE_SZ = ADDR_W'(1) << LINE_BITS;
  localparam logic [ADDR_W-1:0] PAGE_SZ = ADDR_W'(1) << PAGE_BITS;

  logic [ADDR_W-1:0]           prev_addr_q, exp_base_q, step;
  logic [ADDR_W-PAGE_BITS-1:0] inh_page_q;
  logic                        spec_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_addr_q <= '0;
      exp_base_q  <= '0;
      inh_page_q  <= '0;
    end else begin
      prev_addr_q <= fetch_addr_o;
      exp_base_q  <= {ref_addr_i[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      inh_page_q  <= inh_page_i;
    end
  end

  assign step     = fetch_addr_o - prev_addr_q;
  assign spec_bad = ref_spec_i && (!tlb_hit_i || tlb_uncache_i || !xlate_en_i);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o && !fetch_ready_i && !ref_valid_i && !inh_valid_i
    |=> fetch_valid_o && $stable(fetch_addr_o));

  p_forward_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o && fetch_ready_i && !ref_valid_i && !inh_valid_i
    |=> !fetch_valid_o || (step >= LINE_SZ && step <= PAGE_SZ));

  p_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_i && !ref_spec_i &&
    !(inh_valid_i && inh_page_i == ref_addr_i[ADDR_W-1:PAGE_BITS])
    |=> fetch_valid_o && fetch_addr_o == exp_base_q);

  p_inhibit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inh_valid_i
    |=> !(fetch_valid_o && fetch_addr_o[ADDR_W-1:PAGE_BITS] == inh_page_q));

  p_spec_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_i && spec_bad && !busy_i |=> !fetch_valid_o);
endmodule

bind movein_ctrl movein_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .PAGE_BITS(PAGE_BITS),
  .LINE_BITS(LINE_BITS)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ref_valid_i  (ref_valid_i),
  .ref_addr_i   (ref_addr_i),
  .ref_spec_i   (ref_spec_i),
  .tlb_hit_i    (tlb_hit_i),
  .tlb_uncache_i(tlb_uncache_i),
  .xlate_en_i   (xlate_en_i),
  .inh_valid_i  (inh_valid_i),
  .inh_page_i   (inh_page_i),
  .fetch_valid_o(fetch_valid_o),
  .fetch_ready_i(fetch_ready_i),
  .fetch_addr_o (fetch_addr_o),
  .busy_i       (burst_busy)
);

// File: tb/test_movein_ctrl.sv
`timescale 1ns/1ps
module test_movein_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        ref_valid, ref_instr, ref_spec, tlb_hit, tlb_unc, xen;
  logic [31:0] ref_addr;
  logic        inh_valid;
  logic [19:0] inh_page;
  logic        fetch_valid, fetch_ready;
  logic [31:0] fetch_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] got[$];

  always #2.5 clk = ~clk;

  movein_ctrl i_movein_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .ref_valid_i(ref_valid), .ref_addr_i(ref_addr), .ref_instr_i(ref_instr),
    .ref_spec_i(ref_spec), .tlb_hit_i(tlb_hit), .tlb_uncache_i(tlb_unc),
    .xlate_en_i(xen), .inh_valid_i(inh_valid), .inh_page_i(inh_page),
    .fetch_valid_o(fetch_valid), .fetch_ready_i(fetch_ready),
    .fetch_addr_o(fetch_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic send(input logic [31:0] a, input bit ins, input bit sp,
                      input bit hit, input bit unc, input bit x,
                      input bit inh, input logic [19:0] pg);
    fetch_ready = 0;
    ref_valid = 1; ref_addr = a; ref_instr = ins; ref_spec = sp;
    tlb_hit = hit; tlb_unc = unc; xen = x;
    inh_valid = inh; inh_page = pg;
    @(negedge clk);
    ref_valid = 0; inh_valid = 0;
  endtask

  task automatic inhibit(input logic [19:0] pg);
    fetch_ready = 0;
    inh_valid = 1; inh_page = pg;
    @(negedge clk);
    inh_valid = 0;
  endtask

  // mode 0: always ready, 1: every other cycle, 2: every third cycle
  task automatic collect(input int cycles, input int mode, input string req);
    bit          prev_stall = 0;
    logic [31:0] prev_a = '0;
    int          bad = 0;
    for (int c = 0; c < cycles; c++) begin
      fetch_ready = (mode == 0) || (mode == 1 && c % 2 == 0) ||
                    (mode == 2 && c % 3 == 0);
      #1;
      if (prev_stall && !(fetch_valid && fetch_addr == prev_a)) bad++;
      prev_stall = fetch_valid && !fetch_ready;
      prev_a     = fetch_addr;
      if (fetch_valid && fetch_ready) got.push_back(fetch_addr);
      @(negedge clk);
    end
    fetch_ready = 0;
    if (mode != 0) chk(bad == 0, "R9", {"stall hold in ", req}, bad, 0);
  endtask

  task automatic check_seq(input string req, input logic [31:0] base,
                           input int n, input int from);
    int mism = 0;
    for (int i = 0; i < n && from + i < got.size(); i++)
      if (got[from+i] != base + 32'(64 * i)) mism++;
    chk(got.size() >= from + n, req, "fetch count", got.size() - from, n);
    chk(mism == 0, req, "fetch order", mism, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; ref_valid = 0; ref_addr = 0; ref_instr = 0; ref_spec = 0;
    tlb_hit = 0; tlb_unc = 0; xen = 0; inh_valid = 0; inh_page = 0;
    fetch_ready = 0;
    repeat (3) @(negedge clk);
    chk(!fetch_valid, "R10", "valid in reset", fetch_valid, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(!fetch_valid, "R10", "valid after reset", fetch_valid, 0);

    // R1 data burst from mid-page offset
    got.delete();
    send(32'h0001_2345, 0, 0, 0, 0, 0, 0, 0);
    collect(80, 0, "R1");
    check_seq("R1", 32'h0001_2000, 64, 0);
    chk(got.size() == 64, "R1", "exact count", got.size(), 64);

    // R2 instruction burst, stalled every other cycle
    got.delete();
    send(32'h0003_4FC0, 1, 0, 0, 0, 0, 0, 0);
    collect(300, 1, "R2");
    check_seq("R2", 32'h0003_4000, 128, 0);
    chk(got.size() == 128, "R2", "exact count", got.size(), 128);

    // R3 allowed speculative reference
    got.delete();
    send(32'h0004_0800, 0, 1, 1, 0, 1, 0, 0);
    collect(200, 2, "R3");
    check_seq("R3", 32'h0004_0000, 64, 0);

    // R4 rejected speculative references, idle
    got.delete();
    send(32'h0005_1000, 0, 1, 0, 0, 1, 0, 0);
    collect(6, 0, "R4");
    chk(got.size() == 0, "R4", "tlb miss fetches", got.size(), 0);
    send(32'h0005_1000, 1, 1, 1, 1, 1, 0, 0);
    collect(6, 0, "R4");
    chk(got.size() == 0, "R4", "uncacheable fetches", got.size(), 0);
    send(32'h0005_1000, 0, 1, 1, 0, 0, 0, 0);
    collect(6, 0, "R4");
    chk(got.size() == 0, "R4", "xlate off fetches", got.size(), 0);

    // R4 rejected speculative reference during a burst
    got.delete();
    send(32'h000C_0000, 0, 0, 0, 0, 0, 0, 0);
    collect(10, 0, "R4");
    send(32'h000D_0000, 1, 1, 0, 0, 1, 0, 0);
    collect(100, 0, "R4");
    check_seq("R4", 32'h000C_0000, 64, 0);
    chk(got.size() == 64, "R4", "burst unaffected count", got.size(), 64);

    // R5 inhibit mid-burst
    got.delete();
    send(32'h0005_0000, 0, 0, 0, 0, 0, 0, 0);
    collect(5, 0, "R5");
    inhibit(20'h00050);
    collect(20, 0, "R5");
    chk(got.size() == 5, "R5", "fetches after inhibit", got.size(), 5);

    // R6 other page unaffected; R7 second page inhibited
    got.delete();
    send(32'h0006_0000, 0, 0, 0, 0, 0, 0, 0);
    collect(80, 0, "R6");
    chk(got.size() == 64, "R6", "other page count", got.size(), 64);
    got.delete();
    send(32'h0004_F000, 1, 0, 0, 0, 0, 0, 0);
    collect(150, 0, "R7");
    check_seq("R7", 32'h0004_F000, 64, 0);
    chk(got.size() == 64, "R7", "second page dropped", got.size(), 64);
    got.delete();
    send(32'h0005_0040, 0, 0, 0, 0, 0, 0, 0);
    collect(80, 0, "R6");
    check_seq("R6", 32'h0005_0000, 64, 0);

    // R7 first page inhibited after reference
    got.delete();
    send(32'h0008_0000, 1, 0, 0, 0, 0, 0, 0);
    inhibit(20'h00080);
    collect(100, 0, "R7");
    check_seq("R7", 32'h0008_1000, 64, 0);
    chk(got.size() == 64, "R7", "first page skipped", got.size(), 64);

    // R8 abort by new reference
    got.delete();
    send(32'h0009_0000, 0, 0, 0, 0, 0, 0, 0);
    collect(10, 0, "R8");
    send(32'h000A_0000, 1, 0, 0, 0, 0, 0, 0);
    collect(200, 0, "R8");
    check_seq("R8", 32'h0009_0000, 10, 0);
    check_seq("R8", 32'h000A_0000, 128, 10);
    chk(got.size() == 138, "R8", "total after abort", got.size(), 138);

    // R11 round-robin replacement
    for (int p = 1; p <= 5; p++) inhibit(20'(p));
    got.delete();
    send(32'h0000_0000, 1, 0, 0, 0, 0, 0, 0);
    collect(150, 0, "R11");
    chk(got.size() == 128, "R11", "oldest evicted", got.size(), 128);
    got.delete();
    send(32'h0000_3000, 1, 0, 0, 0, 0, 0, 0);
    collect(150, 0, "R11");
    chk(got.size() == 64, "R11", "newer kept", got.size(), 64);

    // R12 inhibit and reference to same page together
    got.delete();
    send(32'h000B_0000, 0, 0, 0, 0, 0, 1, 20'h000B0);
    collect(20, 0, "R12");
    chk(got.size() == 0, "R12", "inhibit wins", got.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule